// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block holds a 256-bit per-device secret and hands it out on the register bus as eight 32-bit words. The secret comes from a constant parameter and is in place as soon as reset is released. Nothing on the bus can write it. Each word can be read out exactly once per power cycle. After that first read, the word is marked consumed and only zero comes back from it until the next reset.

The address decoder supplies three inputs: a word index, a one-cycle read strobe, and a mode bit. When the mode bit is high the processor is running application code. In that mode the whole store is hidden: reads return zero and leave the consumed flags unchanged. Read data is registered and appears in the cycle after the strobe. A flag vector shows which words have already been taken, so the decoder or firmware can see how much of the secret remains.

The secret is little-endian. Byte 0 of the secret parameter is in bits 7:0 of word 0, and word k holds secret bits 32k+31 down to 32k.

Top module: `secret_vault`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_data` is zero and every bit of `consumed` is zero.
- R2: `rd_data` is registered. A strobe at a clock edge shows its result from that edge until the next edge. At an edge with no strobe, `rd_data` becomes zero.
- R3: In firmware mode (`app_mode` = 0), the first strobed read of word k (0..7) returns `SECRET[32k+31:32k]` and sets `consumed[k]` at the same edge. For word 0, byte 0 of the secret is in bits 7:0.
- R4: Any later read of a word whose `consumed` bit is set returns zero.
- R5: A strobed read with `app_mode` = 1 returns zero and changes no `consumed` bit.
- R6: A strobed read with `rd_idx` of 8 or more returns zero and changes no `consumed` bit.
- R7: A `consumed` bit, once set, stays set until reset. Only reset clears it.
- R8: A read of word k changes no `consumed` bit other than bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| rd_stb | input | 1 | One-cycle read strobe from the decoder |
| rd_idx | input | IDX_W (4) | Word index; 0..7 valid |
| app_mode | input | 1 | 1 = application mode, store hidden |
| rd_data | output | 32 | Registered read data |
| consumed | output | NUM_WORDS (8) | Per-word already-read flags |

## Verification
The assertions take for granted that `rd_stb`, `rd_idx` and `app_mode` are stable around each rising edge. They also assume each strobe means exactly one read, so a strobe held high for several cycles counts as several reads. The bench changes these inputs only on falling edges and pulses the strobe for a single cycle. It samples on the following falling edge, so every checked value belongs to exactly one strobe. Out-of-range indices are driven only with values that the 4-bit index can encode (8 and 15).

// File: rtl/vault_pkg.sv
package vault_pkg;
    localparam int unsigned VAULT_WORD_W = 32;

    typedef logic [VAULT_WORD_W-1:0] vault_word_t;

    typedef struct packed {
        logic consumed;
    } slot_state_t;

    typedef struct packed {
        vault_word_t data;
    } port_state_t;
endpackage

// File: rtl/vault_slot.sv
module vault_slot #(
    parameter vault_pkg::vault_word_t WORD_VAL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    output logic                   consumed,
    output vault_pkg::vault_word_t word
);
    vault_pkg::slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.consumed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign consumed = st_q.consumed;
    assign word     = st_q.consumed ? '0 : WORD_VAL;

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consumed |=> consumed);

    // R3
    take_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> consumed);
endmodule

// File: rtl/vault_rd_mux.sv
module vault_rd_mux #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned IDX_W     = 4
) (
    input  vault_pkg::vault_word_t [NUM_WORDS-1:0] words,
    input  logic [IDX_W-1:0]                       idx,
    output vault_pkg::vault_word_t                 sel_word,
    output logic                                   in_range
);
    always_comb begin
        sel_word = '0;
        in_range = 1'b0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (idx == IDX_W'(k)) begin
                sel_word = words[k];
                in_range = 1'b1;
            end
        end
    end
endmodule

// File: rtl/secret_vault.sv
module secret_vault #(
    parameter int unsigned NUM_WORDS = 8,
    parameter int unsigned IDX_W     = 4,
    parameter logic [NUM_WORDS*vault_pkg::VAULT_WORD_W-1:0] SECRET =
        256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_13579bdf_2468ace0_deadbeef_a5c3e1f7
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  rd_stb,
    input  logic [IDX_W-1:0]                      rd_idx,
    input  logic                                  app_mode,
    output logic [vault_pkg::VAULT_WORD_W-1:0]    rd_data,
    output logic [NUM_WORDS-1:0]                  consumed
);
    localparam int unsigned WW = vault_pkg::VAULT_WORD_W;

    vault_pkg::vault_word_t [NUM_WORDS-1:0] slot_words;
    vault_pkg::vault_word_t                 mux_word;
    logic                                   idx_ok;
    logic                                   fw_read;
    logic [NUM_WORDS-1:0]                   take;
    vault_pkg::port_state_t                 pq_d, pq_q;

    assign fw_read = rd_stb && !app_mode;

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
        assign take[k] = fw_read && (rd_idx == IDX_W'(k));
        vault_slot #(
            .WORD_VAL(SECRET[k*WW +: WW])
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take[k]),
            .consumed(consumed[k]),
            .word    (slot_words[k])
        );
    end

    vault_rd_mux #(
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_mux (
        .words   (slot_words),
        .idx     (rd_idx),
        .sel_word(mux_word),
        .in_range(idx_ok)
    );

    always_comb begin
        pq_d = '0;
        if (fw_read) begin
            pq_d.data = mux_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq_q <= '0;
        end else begin
            pq_q <= pq_d;
        end
    end

    assign rd_data = pq_q.data;

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> rd_data == '0);

    // R5
    app_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && app_mode) |=> (rd_data == '0 && $stable(consumed)));

    // R6
    oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !idx_ok) |=> (rd_data == '0 && $stable(consumed)));

    // R4
    reread_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && idx_ok && ((consumed & take) != '0)) |=> rd_data == '0);

    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((consumed & ~$past(consumed)) & ~$past(take)) == '0);
endmodule

// File: tb/sim_secret_vault.sv
module sim_secret_vault;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam logic [255:0] KEY =
        256'h11223344_55667788_99aabbcc_ddeeff00_0badf00d_cafebabe_76543210_fedcba98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic        app_mode = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  consumed;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secret_vault #(.NUM_WORDS(NW), .IDX_W(4), .SECRET(KEY)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_idx(rd_idx),
        .app_mode(app_mode), .rd_data(rd_data), .consumed(consumed)
    );

    function automatic logic [31:0] key_word(int k);
        return KEY[k*32 +: 32];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(int idx, bit app);
        @(negedge clk);
        rd_stb = 1'b1; rd_idx = 4'(idx); app_mode = app;
        @(negedge clk);
        rd_stb = 1'b0; app_mode = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(rd_data == 0, "R1 data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 0, "R1 data after reset", rd_data, 0);
        chk(consumed == 0, "R1 flags after reset", 32'(consumed), 0);
    endtask

    task automatic t_app_mode();
        do_read(2, 1'b1);
        chk(rd_data == 0, "R5 app read data", rd_data, 0);
        chk(consumed == 0, "R5 app read flags", 32'(consumed), 0);
    endtask

    task automatic t_out_of_range();
        do_read(8, 1'b0);
        chk(rd_data == 0, "R6 idx 8 data", rd_data, 0);
        chk(consumed == 0, "R6 idx 8 flags", 32'(consumed), 0);
        do_read(15, 1'b0);
        chk(rd_data == 0, "R6 idx 15 data", rd_data, 0);
        chk(consumed == 0, "R6 idx 15 flags", 32'(consumed), 0);
    endtask

    task automatic t_first_and_second();
        do_read(0, 1'b0);
        chk(rd_data == key_word(0), "R3 word0 data", rd_data, key_word(0));
        chk(rd_data[7:0] == KEY[7:0], "R3 byte0 position", {24'h0, rd_data[7:0]}, {24'h0, KEY[7:0]});
        chk(consumed == 8'h01, "R3 R8 word0 flag only", 32'(consumed), 32'h01);
        @(negedge clk);
        chk(rd_data == 0, "R2 one-cycle data", rd_data, 0);
        do_read(0, 1'b0);
        chk(rd_data == 0, "R4 word0 reread", rd_data, 0);
        chk(consumed == 8'h01, "R7 word0 flag held", 32'(consumed), 32'h01);
    endtask

    task automatic t_all_words();
        logic [7:0] exp_f = 8'h01;
        for (int k = NW - 1; k >= 1; k--) begin
            do_read(k, 1'b0);
            exp_f[k] = 1'b1;
            chk(rd_data == key_word(k), $sformatf("R3 word%0d data", k), rd_data, key_word(k));
            chk(consumed == exp_f, $sformatf("R8 flags after word%0d", k), 32'(consumed), 32'(exp_f));
        end
        do_read(5, 1'b0);
        chk(rd_data == 0, "R4 word5 reread", rd_data, 0);
        do_read(5, 1'b1);
        chk(consumed == 8'hff, "R7 flags in app mode", 32'(consumed), 32'hff);
    endtask

    task automatic t_after_reset();
        do_reset();
        do_read(6, 1'b0);
        chk(rd_data == key_word(6), "R7 word6 readable after reset", rd_data, key_word(6));
        chk(consumed == 8'h40, "R7 only word6 flag", 32'(consumed), 32'h40);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_app_mode();
        t_out_of_range();
        t_first_and_second();
        t_all_words();
        t_after_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule